// File: doc/BRIEF.md
# Page Translation Unit with Miss Handling

The block turns virtual addresses from a processor request port into physical addresses. It keeps recently used translations in a small fully associative cache. Pages are 4 KB, so the low 12 bits of the address pass through unchanged and only the 20-bit virtual page number is translated. When a request hits the cache, the physical address comes back combinationally in the cycle the request is offered, and the memory port is not touched.

When a request misses, the block accepts it and lowers its ready line. It then issues one page-table-entry read on the memory port, at the table base plus four times the virtual page number. When the entry returns marked present, the block completes the translation in that same cycle and writes the entry into the cache. An entry marked not present produces a one-cycle fault pulse that carries the faulting virtual address, and nothing is written into the cache. In both cases the block goes back to idle.

A flush input invalidates every cached translation in one cycle. The victim for a fill is the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the victim.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `fault` and `mem_req_valid` are 0. No slot holds a translation, so the first request misses.
- R2: A request offered while idle whose page is cached gives `rsp_valid`=1 in the same cycle. In that cycle `rsp_pa` = {cached physical page, `req_va[11:0]`}. No memory read follows.
- R3: A miss is accepted at the clock edge. From the next cycle `mem_req_valid` is 1 with `mem_req_addr` = `pt_base` (sampled at acceptance) + VPN*4. Both hold steady until `mem_req_ready` is seen, and exactly one read is issued.
- R4: A returned entry with bit 0 = 1 (present) gives `rsp_valid`=1 in the cycle `mem_rsp_valid` is high. In that cycle `rsp_pa` = {entry bits 31:12, request offset}. The translation is cached, so a later request to the same page hits.
- R5: A returned entry with bit 0 = 0 gives `fault`=1 for exactly one cycle, with `fault_va` equal to the request address and `rsp_valid`=0. Nothing is cached, and the unit is idle in the next cycle.
- R6: Any page may occupy any of the ENTRIES slots (default 256). After ENTRIES distinct pages are filled, all of them hit.
- R7: A fill uses the lowest-numbered empty slot. When every slot is full, the victim is chosen round-robin from slot 0 upward.
- R8: `flush` invalidates every slot in one cycle. When a flush coincides with a fill, the flush wins: the translation is still delivered, but a later request to that page misses.
- R9: While a miss is outstanding, `req_ready` is 0 and further requests are held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 32 | Page-table base address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation complete this cycle |
| rsp_pa | output | 32 | Physical address |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_va | output | 32 | Faulting virtual address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Page-table entry |

## Verification
A flush and a fill can land in the same cycle. The bench provokes this by raising `flush` in the very cycle it returns a present entry, both in a directed case and at random points in the random phase. It judges the outcome in two steps: the translation must still be delivered in that cycle, and a later request to the same page must miss and issue a fresh table read. A flush in the same cycle as a hit is judged the same way, with the hit served and the following request missing.

// File: rtl/xlat_pkg.sv
// Shared types for the translation unit.
// Assumes: nothing beyond IEEE 1800-2017.
package xlat_pkg;

    // Miss sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2
    } walk_state_t;

endpackage

// File: rtl/xlat_tlb_store.sv
// Fully associative translation store: parallel tag compare, one-hot hit,
// single-slot fill, whole-array flush.
// Assumes: the caller never fills a page that already resides (it fills only
// after a miss), so at most one slot matches.
module xlat_tlb_store #(
    parameter int ENTRIES = 256,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    // Per-slot tag comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end

    // OR-reduce the matching slot's physical page onto the output.
    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
        end
    end

    assign lk_hit    = |hit_vec;
    assign valid_vec = valid_q;

    // Valid bits: cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid_q <= '0;
        else if (fill_en)    valid_q[fill_idx] <= 1'b1;
    end

    // Tag and page payload written on fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_vpn;
            ppn_q[fill_idx] <= fill_ppn;
        end
    end

    // R6
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

endmodule

// File: rtl/xlat_victim.sv
// Victim selection: the lowest empty slot if one exists, else a round-robin
// pointer that advances only on fills into a full array.
// Assumes: fill_en is high only for fills that really take effect.
module xlat_victim #(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               fill_en,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] first_free;
    logic             any_free;
    logic [IDX_W-1:0] rr_q;

    // Priority encoder: find the lowest-numbered empty slot.
    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                first_free = IDX_W'(i);
                any_free   = 1'b1;
            end
        end
    end

    assign victim_idx = any_free ? first_free : rr_q;

    // Round-robin pointer advances past each slot it evicts.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rr_q <= '0;
        else if (fill_en && !any_free)  rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end

endmodule

// File: rtl/xlat_walker.sv
// Miss sequencer: captures a missing request, issues one page-table read,
// waits for the entry, and reports a good or bad completion.
// Assumes: memory returns exactly one response per accepted read.
module xlat_walker #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_va,
    input  logic            lk_hit,
    input  logic [VA_W-1:0] pt_base,
    output logic            idle,
    output logic [VA_W-1:0] pend_va,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic            pte_present,
    output logic            done_ok,
    output logic            done_bad
);
    import xlat_pkg::*;

    localparam int VPN_W = VA_W - PAGE_BITS;

    walk_state_t     state_q;
    logic [VA_W-1:0] addr_q;
    logic [VA_W-1:0] va_q;
    logic            done;

    assign idle          = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_MREQ);
    assign mem_req_addr  = addr_q;
    assign pend_va       = va_q;
    assign done          = (state_q == ST_MWAIT) && mem_rsp_valid;
    assign done_ok       = done && pte_present;
    assign done_bad      = done && !pte_present;

    // State register: idle -> request -> wait -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:  if (req_valid && !lk_hit) state_q <= ST_MREQ;
                ST_MREQ:  if (mem_req_ready)        state_q <= ST_MWAIT;
                ST_MWAIT: if (mem_rsp_valid)        state_q <= ST_IDLE;
                default:                            state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the missing address and its table-entry address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            addr_q <= '0;
        end else if (idle && req_valid && !lk_hit) begin
            va_q   <= req_va;
            addr_q <= pt_base + VA_W'({req_va[VA_W-1 -: VPN_W], 2'b00});
        end
    end

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/xlat_unit.sv
// Top of the translation unit: same-cycle hits from the associative store,
// one-read misses through the walker, fault pulse on a non-present entry.
// Assumes: single-level table of 32-bit entries, present flag in bit 0,
// physical page in the bits above the page offset.
module xlat_unit #(
    parameter int VA_W      = 32,
    parameter int PTE_W     = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [VA_W-1:0]               pt_base,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_va,
    output logic                          rsp_valid,
    output logic [PTE_W-1:0]              rsp_pa,
    output logic                          fault,
    output logic [VA_W-1:0]               fault_va,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [VA_W-1:0]               mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [PTE_W-1:0]              mem_rsp_data
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PTE_W - PAGE_BITS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic               lk_hit;
    logic [PPN_W-1:0]   lk_ppn;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic [VA_W-1:0]    pend_va;
    logic               done_ok;
    logic               done_bad;
    logic               fill_en;
    logic               hit_serve;
    logic               unused_pte_bits;

    assign unused_pte_bits = ^mem_rsp_data[PAGE_BITS-1:1];
    assign fill_en   = done_ok && !flush;
    assign hit_serve = req_ready && req_valid && lk_hit;
    assign rsp_valid = hit_serve || done_ok;
    assign fault     = done_bad;
    assign fault_va  = pend_va;

    // Result mux: walker completion or cached hit.
    always_comb begin
        if (done_ok) rsp_pa = {mem_rsp_data[PTE_W-1:PAGE_BITS], pend_va[PAGE_BITS-1:0]};
        else         rsp_pa = {lk_ppn, req_va[PAGE_BITS-1:0]};
    end

    xlat_tlb_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (req_va[VA_W-1:PAGE_BITS]),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .fill_en   (fill_en),
        .fill_idx  (victim_idx),
        .fill_vpn  (pend_va[VA_W-1:PAGE_BITS]),
        .fill_ppn  (mem_rsp_data[PTE_W-1:PAGE_BITS]),
        .valid_vec (valid_vec)
    );

    xlat_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .fill_en    (fill_en),
        .victim_idx (victim_idx)
    );

    xlat_walker #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .lk_hit        (lk_hit),
        .pt_base       (pt_base),
        .idle          (req_ready),
        .pend_va       (pend_va),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .pte_present   (mem_rsp_data[0]),
        .done_ok       (done_ok),
        .done_bad      (done_bad)
    );

    // R4
    rsp_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fault));

    // R5
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (req_ready && !fault));

    // R2
    hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_serve |=> !mem_req_valid);

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);

endmodule

// File: tb/xlat_unit_bench.sv
`timescale 1ns/1ps
module xlat_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        fault;
    logic [31:0] fault_va;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit cached [16];

    always #4 clk = ~clk;

    xlat_unit u_xlat_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .fault(fault), .fault_va(fault_va),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // Table model: high pages always present, low pages absent when VPN%5==0.
    function automatic bit pte_ok(input logic [19:0] vpn);
        if (vpn[19]) return 1'b1;
        return (vpn % 20'd5) != 20'd0;
    endfunction

    function automatic logic [19:0] ppn_of(input logic [19:0] vpn);
        return (vpn * 20'd7 + 20'd3) ^ 20'h5a5a5;
    endfunction

    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        return {ppn_of(vpn), 11'h2a5, pte_ok(vpn)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    // One request through hit or miss; table memory modelled here.
    task automatic access(input logic [31:0] va, input bit exp_hit, input bit flush_done, input int stall);
        logic [19:0] vpn;
        logic [31:0] exp_addr;
        vpn = va[31:12];
        @(negedge clk); req_valid = 1'b1; req_va = va; #1;
        chk(req_ready, "R9 ready while idle", 32'(req_ready), 32'd1);
        chk(rsp_valid == exp_hit, exp_hit ? "R2 expected hit" : "R3 expected miss", 32'(rsp_valid), 32'(exp_hit));
        if (rsp_valid) begin
            chk(rsp_pa == {ppn_of(vpn), va[11:0]}, "R2 hit address", rsp_pa, {ppn_of(vpn), va[11:0]});
            @(negedge clk); req_valid = 1'b0; #1;
            chk(!mem_req_valid, "R2 no table read on hit", 32'(mem_req_valid), 32'd0);
            return;
        end
        exp_addr = pt_base + {10'd0, vpn, 2'b00};
        @(negedge clk); req_valid = 1'b0; #1;
        chk(!req_ready, "R9 held off during miss", 32'(req_ready), 32'd0);
        chk(mem_req_valid && mem_req_addr == exp_addr, "R3 table read address", mem_req_addr, exp_addr);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk); #1;
            chk(mem_req_valid && mem_req_addr == exp_addr, "R3 read held stable", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk); mem_req_ready = 1'b0; #1;
        chk(!mem_req_valid && !req_ready, "R3 single read issued", 32'(mem_req_valid), 32'd0);
        for (int k = 0; k < stall; k++) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = pte_of(vpn); flush = flush_done; #1;
        if (pte_ok(vpn)) begin
            chk(rsp_valid && !fault, "R4 completion on present entry", 32'(rsp_valid), 32'd1);
            chk(rsp_pa == {ppn_of(vpn), va[11:0]}, "R4 filled address", rsp_pa, {ppn_of(vpn), va[11:0]});
        end else begin
            chk(fault && !rsp_valid, "R5 fault on absent entry", 32'(fault), 32'd1);
            chk(fault_va == va, "R5 fault address", fault_va, va);
        end
        @(negedge clk); mem_rsp_valid = 1'b0; flush = 1'b0; #1;
        chk(req_ready && !fault, "R5 back to idle after walk", 32'(fault), 32'd0);
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !rsp_valid && !fault && !mem_req_valid, "R1 reset outputs",
            {28'd0, req_ready, rsp_valid, fault, mem_req_valid}, 32'h8);
        rst_n = 1'b1;

        // R1 first request misses; R4 then it hits; R2 different offset.
        access(32'h0000_1abc, 1'b0, 1'b0, 1);
        access(32'h0000_1fff, 1'b1, 1'b0, 0);
        // R5 absent entry faults and is not cached.
        access(32'h0000_5123, 1'b0, 1'b0, 2);
        access(32'h0000_5123, 1'b0, 1'b0, 0);
        // R8 flush coinciding with fill: delivered but not kept.
        access(32'h0000_2010, 1'b0, 1'b1, 1);
        access(32'h0000_2010, 1'b0, 1'b0, 0);
        access(32'h0000_2444, 1'b1, 1'b0, 0);
        // R8 flush on its own, also in the same cycle as a hit.
        @(negedge clk); flush = 1'b1; req_valid = 1'b1; req_va = 32'h0000_2004; #1;
        chk(rsp_valid && rsp_pa == {ppn_of(20'h2), 12'h004}, "R8 hit served alongside flush", rsp_pa, {ppn_of(20'h2), 12'h004});
        @(negedge clk); flush = 1'b0; req_valid = 1'b0;
        access(32'h0000_2004, 1'b0, 1'b0, 0);
        access(32'h0000_1abc, 1'b0, 1'b0, 0);
        // R3 base register change.
        pt_base = 32'h8000_0000;
        access(32'h0003_3000, 1'b0, 1'b0, 0);
        pt_base = 32'h0010_0000;

        // R6 capacity, R7 replacement order.
        do_flush();
        for (int i = 0; i < 256; i++) access({20'h80000 + 20'(i), 12'h0}, 1'b0, 1'b0, 0);
        for (int i = 0; i < 256; i++) access({20'h80000 + 20'(i), 12'h8}, 1'b1, 1'b0, 0);
        access({20'h80100, 12'h0}, 1'b0, 1'b0, 0);   // R7 evicts slot 0
        access({20'h80000, 12'h0}, 1'b0, 1'b0, 0);   // R7 evicts slot 1
        access({20'h80002, 12'h0}, 1'b1, 1'b0, 0);   // R7 slot 2 survives
        access({20'h80001, 12'h0}, 1'b0, 1'b0, 0);   // R7 slot 1 page gone
        access({20'h80100, 12'h0}, 1'b1, 1'b0, 0);   // R7 new page kept

        // Random phase over a small page pool.
        do_flush();
        for (int i = 0; i < 16; i++) cached[i] = 1'b0;
        for (int n = 0; n < 400; n++) begin
            logic [3:0] v;
            bit fl;
            v  = 4'($urandom % 16);
            fl = ($urandom % 10) == 0;
            if (($urandom % 25) == 0) begin
                do_flush();
                for (int i = 0; i < 16; i++) cached[i] = 1'b0;
            end
            access({16'd0, v, 12'($urandom)}, cached[v], fl, int'($urandom % 3));
            if (!cached[v] && pte_ok({16'd0, v})) cached[v] = !fl;
            if (!cached[v] && fl) for (int i = 0; i < 16; i++) cached[i] = 1'b0;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule